// File: doc/BRIEF.md
# Tape Pulse Waveform Generator

This block rebuilds the EAR signal of a cassette recorder from a byte stream that an upstream agent writes into a FIFO. Each FIFO entry is a byte plus a flag that says whether it is a command or a data byte. A command opcode is always followed by two argument bytes, low byte first. With these commands the producer sets the half-pulse widths used for 0 and 1 bits, the number of bytes in a data block, the number of unused bits in the last byte of that block, and a repeat count for the next pulse or gap command. Other commands emit a pulse or a silent gap, or discard pending playback and settings. Data bytes that arrive while a block length is pending are sent out as bit pairs, most significant bit first.

All durations are counted in T-state ticks. A ticks input, one clock-wide pulse per T-state from a divider, supplies them. The ticks must be at least six clock cycles apart so that fetching the next command or byte never costs a tick. The block reads the FIFO, a show-ahead FIFO with data valid while it is non-empty, through a pop strobe. It pops only when it is idle, when it is collecting argument bytes, or when a discard command sits at the head of the FIFO during playback.

Top module: `tape_wave_gen`

## Requirements
- R1: After reset, `ear`, `fifo_pop` and `active` are low. The 0-bit and 1-bit widths start at 855 and 1710 ticks.
- R2: Opcode 0x80 sets the 0-bit half-pulse width and opcode 0x81 sets the 1-bit half-pulse width. Both take their 16-bit argument from the two bytes that follow the opcode, low byte first.
- R3: Each data bit is played as two half-pulses of the width chosen by its value, most significant bit first. `ear` toggles at the end of each half-pulse, so the edges are exactly that many ticks apart.
- R4: A data byte (flag low) that arrives while the pending block byte count is zero is popped and dropped, and `ear` does not change. Opcode 0x83 loads the byte count, and each byte played decrements it.
- R5: Opcode 0x84 loads the number of unused bits (argument bits 2:0) for the last byte of a block. The last byte then plays only its top 8 minus that many bits, and the other bytes of the block play all 8 bits.
- R6: Opcode 0x86 plays pulses of the argument length in ticks, each ending in an `ear` toggle. With a pending repeat count N it plays N+1 such pulses back to back.
- R7: Opcode 0x85 sets the repeat count. A count of 0 plays once. The count is used by the next 0x86 or 0x82 only, and the command after that plays once.
- R8: Opcode 0x82 drives `ear` low at once and holds it low, with no toggle, for the argument length times (repeat count + 1) ticks.
- R9: Opcode 0x87 clears the byte count, the unused-bit count and the repeat count. If it reaches the FIFO head while a pulse, gap or bit is playing, it is popped at once and playback stops without another `ear` toggle.
- R10: `fifo_pop` is never high while `fifo_empty` is high. During playback it rises only for a discard command at the head.
- R11: A pulse, gap or width argument of 0 lasts one tick.
- R12: `active` is high from the clock edge that starts a pulse, gap or bit until the edge that ends the last one. For a pulse command it stays high for length times (repeat + 1) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per T-state |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_is_cmd | input | 1 | Head entry is an opcode (1) or a data/argument byte (0) |
| fifo_data | input | 8 | Head entry byte |
| fifo_pop | output | 1 | Removes the head entry at this clock edge |
| ear | output | 1 | Generated tape signal |
| active | output | 1 | A pulse, gap or data bit is playing |

## Verification
A pop takes effect at the same clock edge that consumes the byte. A timed segment is loaded at that edge, and the tick arriving at that edge is not counted. Each `ear` edge and each fall of `active` lands on the clock edge that carries the tick completing the programmed width, so every expected result is a count of ticks after the edge where `active` rose or after the previous `ear` edge. The bench samples the outputs on the falling clock edge. It stamps each `ear` edge and each `active` transition with a running tick count, then compares the differences between stamps with widths computed from the requirements, so it does not need to know how many clock cycles command decoding takes.

// File: rtl/tape_wave_pkg.sv
package tape_wave_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ARG_W  = 2 * BYTE_W;
  localparam int unsigned BITCNT_W = $clog2(BYTE_W) + 1;

  typedef enum logic [BYTE_W-1:0] {
    OP_ZERO_W = 8'h80,
    OP_ONE_W  = 8'h81,
    OP_GAP    = 8'h82,
    OP_LEN    = 8'h83,
    OP_PAD    = 8'h84,
    OP_REP    = 8'h85,
    OP_PULSE  = 8'h86,
    OP_FLUSH  = 8'h87
  } tape_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARG_LO, ST_ARG_HI, ST_TIMED, ST_BIT
  } tape_st_e;

  // width of one half-pulse for a given bit value
  function automatic logic [ARG_W-1:0] half_width(input logic bit_v,
                                                  input logic [ARG_W-1:0] zw,
                                                  input logic [ARG_W-1:0] ow);
    return bit_v ? ow : zw;
  endfunction

  // number of bits played from a byte
  function automatic logic [BITCNT_W-1:0] bits_in_byte(input logic is_last,
                                                       input logic [2:0] pad);
    return is_last ? BITCNT_W'(BYTE_W) - {1'b0, pad} : BITCNT_W'(BYTE_W);
  endfunction
endpackage

// File: rtl/tape_tick_timer.sv
module tape_tick_timer #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             stop,
  input  logic [WIDTH-1:0] len,
  output logic             expire
);
  logic [WIDTH-1:0] cnt_q;
  logic             run_q;

  assign expire = run_q && tick && (cnt_q < WIDTH'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= len;
      run_q <= 1'b1;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (run_q && tick) begin
      if (cnt_q < WIDTH'(2)) run_q <= 1'b0;
      else                   cnt_q <= cnt_q - WIDTH'(1);
    end
  end

  // R6
  expire_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load && !stop) |=> !run_q);
  // R11
  load_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> run_q);
endmodule

// File: rtl/tape_cmd_ctrl.sv
module tape_cmd_ctrl
  import tape_wave_pkg::*;
#(
  parameter int unsigned ZERO_W_RST = 855,
  parameter int unsigned ONE_W_RST  = 1710
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic              fifo_is_cmd,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              tmr_expire,
  output logic              fifo_pop,
  output logic              tmr_load,
  output logic              tmr_stop,
  output logic [ARG_W-1:0]  tmr_len,
  output logic              ear,
  output logic              active
);
  tape_st_e              state_q;
  logic [BYTE_W-1:0]     op_q, arg_lo_q, shreg_q;
  logic [ARG_W-1:0]      zero_w_q, one_w_q, byte_cnt_q, rep_q, run_left_q, span_q;
  logic [2:0]            pad_q;
  logic [BITCNT_W-1:0]   bit_left_q;
  logic                  is_gap_q, half_q, ear_q;

  logic                  head_flush, playing;
  logic [ARG_W-1:0]      arg_full;

  assign head_flush = !fifo_empty && fifo_is_cmd && (fifo_data == OP_FLUSH);
  assign playing    = (state_q == ST_TIMED) || (state_q == ST_BIT);
  assign arg_full   = {fifo_data, arg_lo_q};
  assign ear        = ear_q;
  assign active     = playing;

  always_comb begin
    fifo_pop = 1'b0;
    tmr_load = 1'b0;
    tmr_stop = 1'b0;
    tmr_len  = span_q;
    case (state_q)
      ST_IDLE: if (!fifo_empty) begin
        fifo_pop = 1'b1;
        if (!fifo_is_cmd && byte_cnt_q != '0) begin
          tmr_load = 1'b1;
          tmr_len  = half_width(fifo_data[BYTE_W-1], zero_w_q, one_w_q);
        end
      end
      ST_ARG_LO: fifo_pop = !fifo_empty;
      ST_ARG_HI: if (!fifo_empty) begin
        fifo_pop = 1'b1;
        if (op_q == OP_GAP || op_q == OP_PULSE) begin
          tmr_load = 1'b1;
          tmr_len  = arg_full;
        end
      end
      ST_TIMED: if (head_flush) begin
        fifo_pop = 1'b1;
        tmr_stop = 1'b1;
      end else if (tmr_expire && run_left_q != '0) begin
        tmr_load = 1'b1;
      end
      ST_BIT: if (head_flush) begin
        fifo_pop = 1'b1;
        tmr_stop = 1'b1;
      end else if (tmr_expire) begin
        if (!half_q) begin
          tmr_load = 1'b1;
          tmr_len  = half_width(shreg_q[BYTE_W-1], zero_w_q, one_w_q);
        end else if (bit_left_q > BITCNT_W'(1)) begin
          tmr_load = 1'b1;
          tmr_len  = half_width(shreg_q[BYTE_W-2], zero_w_q, one_w_q);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_q       <= '0;
      arg_lo_q   <= '0;
      shreg_q    <= '0;
      zero_w_q   <= ARG_W'(ZERO_W_RST);
      one_w_q    <= ARG_W'(ONE_W_RST);
      byte_cnt_q <= '0;
      rep_q      <= '0;
      run_left_q <= '0;
      span_q     <= '0;
      pad_q      <= '0;
      bit_left_q <= '0;
      is_gap_q   <= 1'b0;
      half_q     <= 1'b0;
      ear_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (!fifo_empty) begin
          if (fifo_is_cmd) begin
            op_q    <= fifo_data;
            state_q <= ST_ARG_LO;
          end else if (byte_cnt_q != '0) begin
            shreg_q    <= fifo_data;
            bit_left_q <= bits_in_byte(byte_cnt_q == ARG_W'(1), pad_q);
            half_q     <= 1'b0;
            state_q    <= ST_BIT;
          end
        end
        ST_ARG_LO: if (!fifo_empty) begin
          arg_lo_q <= fifo_data;
          state_q  <= ST_ARG_HI;
        end
        ST_ARG_HI: if (!fifo_empty) begin
          state_q <= ST_IDLE;
          case (op_q)
            OP_ZERO_W: zero_w_q   <= arg_full;
            OP_ONE_W:  one_w_q    <= arg_full;
            OP_LEN:    byte_cnt_q <= arg_full;
            OP_PAD:    pad_q      <= arg_full[2:0];
            OP_REP:    rep_q      <= arg_full;
            OP_GAP, OP_PULSE: begin
              is_gap_q   <= (op_q == OP_GAP);
              span_q     <= arg_full;
              run_left_q <= rep_q;
              rep_q      <= '0;
              if (op_q == OP_GAP) ear_q <= 1'b0;
              state_q    <= ST_TIMED;
            end
            OP_FLUSH: begin
              byte_cnt_q <= '0;
              rep_q      <= '0;
              pad_q      <= '0;
            end
            default: ;
          endcase
        end
        ST_TIMED: if (head_flush) begin
          op_q    <= OP_FLUSH;
          state_q <= ST_ARG_LO;
        end else if (tmr_expire) begin
          if (!is_gap_q) ear_q <= ~ear_q;
          if (run_left_q != '0) run_left_q <= run_left_q - ARG_W'(1);
          else                  state_q    <= ST_IDLE;
        end
        ST_BIT: if (head_flush) begin
          op_q    <= OP_FLUSH;
          state_q <= ST_ARG_LO;
        end else if (tmr_expire) begin
          ear_q <= ~ear_q;
          if (!half_q) begin
            half_q <= 1'b1;
          end else if (bit_left_q > BITCNT_W'(1)) begin
            shreg_q    <= shreg_q << 1;
            bit_left_q <= bit_left_q - BITCNT_W'(1);
            half_q     <= 1'b0;
          end else begin
            byte_cnt_q <= byte_cnt_q - ARG_W'(1);
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  // R9
  flush_stops_play_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && fifo_pop) |=> (state_q == ST_ARG_LO));
  // R8
  gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TIMED && is_gap_q) |-> !ear_q);
  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BIT && !tmr_expire) |=> $stable(ear_q));
  // R4
  drop_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !fifo_empty && !fifo_is_cmd && byte_cnt_q == '0)
      |=> (state_q == ST_IDLE && $stable(ear_q)));
endmodule

// File: rtl/tape_wave_gen.sv
module tape_wave_gen
  import tape_wave_pkg::*;
#(
  parameter int unsigned ZERO_W_RST = 855,
  parameter int unsigned ONE_W_RST  = 1710
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fifo_empty,
  input  logic       fifo_is_cmd,
  input  logic [7:0] fifo_data,
  output logic       fifo_pop,
  output logic       ear,
  output logic       active
);
  logic             tmr_load, tmr_stop, tmr_expire;
  logic [ARG_W-1:0] tmr_len;

  tape_cmd_ctrl #(
    .ZERO_W_RST(ZERO_W_RST),
    .ONE_W_RST (ONE_W_RST)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .fifo_is_cmd(fifo_is_cmd),
    .fifo_data  (fifo_data),
    .tmr_expire (tmr_expire),
    .fifo_pop   (fifo_pop),
    .tmr_load   (tmr_load),
    .tmr_stop   (tmr_stop),
    .tmr_len    (tmr_len),
    .ear        (ear),
    .active     (active)
  );

  tape_tick_timer #(.WIDTH(ARG_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .load  (tmr_load),
    .stop  (tmr_stop),
    .len   (tmr_len),
    .expire(tmr_expire)
  );
endmodule

// File: tb/tape_wave_gen_tb.sv
`timescale 1ns/1ps
module tape_wave_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [2:0] tdiv = '0;
  logic [7:0] fmem [0:255];
  logic       fcmd [0:255];
  logic [7:0] rd = '0;
  logic [7:0] wr = '0;
  wire        fifo_empty = (rd == wr);
  wire  [7:0] fifo_data = fmem[rd];
  wire        fifo_is_cmd = fcmd[rd];
  logic fifo_pop, ear, active;

  int checks = 0, errors = 0;
  int tick_no = 0;
  int n_edges = 0;
  int edge_t [0:1023];
  int rise_t = 0, fall_t = 0, viol = 0;
  logic prev_ear = 1'b0, prev_act = 1'b0;

  tape_wave_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_empty(fifo_empty),
    .fifo_is_cmd(fifo_is_cmd), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .ear(ear), .active(active));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 3'd1;
    tick <= (tdiv == 3'd6);
    if (tick) tick_no <= tick_no + 1;
    if (fifo_pop) rd <= rd + 8'd1;
  end

  always @(negedge clk) begin
    if (ear !== prev_ear) begin
      edge_t[n_edges] = tick_no;
      n_edges = n_edges + 1;
    end
    prev_ear = ear;
    if (active && !prev_act) rise_t = tick_no;
    if (!active && prev_act) fall_t = tick_no;
    prev_act = active;
    if (fifo_pop && fifo_empty) viol = viol + 1;
  end

  // stimulus table: {0-bit width, 1-bit width, data byte, unused bits}
  localparam logic [47:0] VEC [0:3] = '{
    {16'd3, 16'd6, 8'hA5, 8'd0},
    {16'd2, 16'd5, 8'h3C, 8'd0},
    {16'd4, 16'd1, 8'h80, 8'd5},
    {16'd1, 16'd2, 8'h00, 8'd7}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic c);
    @(negedge clk);
    fmem[wr] = b;
    fcmd[wr] = c;
    wr = wr + 8'd1;
  endtask

  task automatic cmd(input logic [7:0] op, input logic [15:0] arg);
    push(op, 1'b1);
    push(arg[7:0], 1'b0);
    push(arg[15:8], 1'b0);
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 12) begin
      @(negedge clk);
      if (fifo_empty && !active) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, bad, prev;
    for (int i = 0; i < 256; i++) begin fmem[i] = '0; fcmd[i] = 1'b0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ear == 1'b0 && fifo_pop == 1'b0 && active == 1'b0, "R1 reset outputs",
        {ear, fifo_pop, active}, 0);

    // R4 data byte without a pending block length is dropped
    base = n_edges;
    push(8'h55, 1'b0);
    wait_idle();
    chk(n_edges == base, "R4 dropped byte edges", n_edges - base, 0);
    chk(rd == wr, "R4 dropped byte popped", rd, wr);

    // table-driven R2 R3 R5
    for (int r = 0; r < 4; r++) begin
      logic [15:0] zw, ow;
      logic [7:0]  db;
      int nb, w;
      zw = VEC[r][47:32]; ow = VEC[r][31:16]; db = VEC[r][15:8];
      nb = 8 - int'(VEC[r][2:0]);
      cmd(8'h80, zw);
      cmd(8'h81, ow);
      cmd(8'h83, 16'd1);
      cmd(8'h84, {8'd0, VEC[r][7:0]});
      base = n_edges;
      push(db, 1'b0);
      wait_idle();
      chk(n_edges - base == 2 * nb, "R3 R5 edge count", n_edges - base, 2 * nb);
      bad = 0;
      prev = rise_t;
      for (int k = 0; k < 2 * nb; k++) begin
        w = db[7 - k / 2] ? int'(ow) : int'(zw);
        if (edge_t[base + k] - prev != w) bad++;
        prev = edge_t[base + k];
      end
      chk(bad == 0, "R2 R3 half-pulse widths", bad, 0);
    end

    // R5 multi-byte block: unused bits only in the last byte
    cmd(8'h80, 16'd2);
    cmd(8'h81, 16'd3);
    cmd(8'h83, 16'd2);
    cmd(8'h84, 16'd4);
    base = n_edges;
    push(8'hF0, 1'b0);
    push(8'hF0, 1'b0);
    wait_idle();
    chk(n_edges - base == 24, "R5 two-byte block edges", n_edges - base, 24);

    // R6 repeated pulse, R12 active span
    cmd(8'h85, 16'd2);
    base = n_edges;
    cmd(8'h86, 16'd3);
    wait_idle();
    chk(n_edges - base == 3, "R6 repeated pulse edges", n_edges - base, 3);
    bad = 0;
    prev = rise_t;
    for (int k = 0; k < 3; k++) begin
      if (edge_t[base + k] - prev != 3) bad++;
      prev = edge_t[base + k];
    end
    chk(bad == 0, "R6 pulse spacing", bad, 0);
    chk(fall_t - rise_t == 9, "R12 active span", fall_t - rise_t, 9);

    // R7 repeat consumed, then repeat 0 plays once
    base = n_edges;
    cmd(8'h86, 16'd3);
    wait_idle();
    chk(n_edges - base == 1, "R7 repeat consumed", n_edges - base, 1);
    cmd(8'h85, 16'd0);
    base = n_edges;
    cmd(8'h86, 16'd2);
    wait_idle();
    chk(n_edges - base == 1, "R7 repeat zero once", n_edges - base, 1);

    // R11 zero length lasts one tick
    base = n_edges;
    cmd(8'h86, 16'd0);
    wait_idle();
    chk(n_edges - base == 1 && edge_t[base] - rise_t == 1, "R11 zero length",
        edge_t[base] - rise_t, 1);

    // R8 gap: make ear high first
    if (ear == 1'b0) begin
      cmd(8'h86, 16'd2);
      wait_idle();
    end
    cmd(8'h85, 16'd1);
    base = n_edges;
    cmd(8'h82, 16'd5);
    while (!active) @(negedge clk);
    repeat (24) @(negedge clk);
    chk(ear == 1'b0 && active == 1'b1, "R8 ear low mid gap", {ear, active}, 1);
    wait_idle();
    chk(n_edges - base == 1, "R8 gap edges", n_edges - base, 1);
    chk(fall_t - rise_t == 10, "R8 gap span", fall_t - rise_t, 10);

    // R9 discard during playback
    cmd(8'h83, 16'd2);
    cmd(8'h85, 16'd5);
    cmd(8'h86, 16'd50);
    while (!active) @(negedge clk);
    repeat (40) @(negedge clk);
    base = n_edges;
    cmd(8'h87, 16'd0);
    push(8'hFF, 1'b0);
    wait_idle();
    chk(n_edges == base, "R9 playback stopped, data dropped", n_edges - base, 0);
    chk(fall_t - rise_t < 50, "R9 active cut short", fall_t - rise_t, 49);
    base = n_edges;
    push(8'hAA, 1'b0);
    wait_idle();
    chk(n_edges == base, "R9 byte count cleared", n_edges - base, 0);
    cmd(8'h85, 16'd3);
    cmd(8'h87, 16'd0);
    base = n_edges;
    cmd(8'h86, 16'd2);
    wait_idle();
    chk(n_edges - base == 1, "R9 repeat cleared", n_edges - base, 1);

    // R10 pop discipline
    chk(viol == 0, "R10 pop while empty", viol, 0);
    chk(rd == wr, "R10 FIFO drained", rd, wr);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule